// File: doc/BRIEF.md
# Core Wrapper Boundary Cell

This block is one boundary storage cell of a test wrapper placed around an embedded core. It sits on a single core terminal, or on a bus of `DW` terminals, between the core and the rest of the chip. It has a functional path, a serial scan path, a two-bit mode selector and a set of event strobes. In functional mode it is a plain wire. In the two test-facing modes it either drives a stored test value or lets the functional value through. In safe mode it forces a fixed, parameterised value.

The cell holds a shift stage. The parameter `HAS_UPDATE` can add an update stage behind it. When the update stage is present, the applied test value stays still while new data shifts through the chain. The parameter `CORE_INPUT` says which side the cell drives:

- `CORE_INPUT = 1`: the cell sits on a core input, and it drives its stored value in inward-facing mode.
- `CORE_INPUT = 0`: the cell sits on a core output, and it drives its stored value in outward-facing mode.

In the other facing mode the cell only observes: it captures data and passes the functional value through. Many such cells are chained through `scan_i`/`scan_o` by the wrapper that uses them.

Top module: `wbc_cell`

## Requirements
- R1: With mode code 2'b00 (functional), `func_o` equals `func_i` combinationally, with no register in the path.
- R2: With mode code 2'b11 (safe), `func_o` equals the parameter `SAFE_VALUE`, whatever the other inputs are.
- R3: A rising clock edge with `shift_en_i` high shifts the shift stage one place toward its MSB and loads `scan_i` into bit 0. `scan_o` always shows the MSB (bit `DW-1`) of the shift stage.
- R4: A rising edge with `capture_en_i` high, and no higher-priority strobe, loads `func_i` into the shift stage.
- R5: With `HAS_UPDATE=1`, a rising edge with `update_en_i` high, and no other strobe, copies the shift stage into the update stage.
- R6: A rising edge with `transfer_en_i` high, and no higher-priority strobe, copies the update stage into the shift stage. With `HAS_UPDATE=0` it leaves the shift stage unchanged.
- R7: The strobes are mutually exclusive in effect, with priority shift > capture > transfer > update. Only the highest-priority asserted strobe acts, and with no strobe both stages hold.
- R8: In the driving mode (2'b01 inward if `CORE_INPUT=1`, 2'b10 outward if `CORE_INPUT=0`), `func_o` is the stored value while `apply_en_i` is high, and `func_i` while it is low. The stored value is the update stage, or the shift stage when `HAS_UPDATE=0`.
- R9: In the other facing mode (the observing mode), `func_o` equals `func_i`.
- R10: With `HAS_UPDATE=1`, the update stage, and hence a driven `func_o`, changes only on an update event, so shifting causes no ripple on the output.
- R11: Asserting `arst_n` low clears both stages to zero at once. Strobes take effect only after reset has been released for two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 functional, 01 inward, 10 outward, 11 safe |
| shift_en_i | input | 1 | Shift event strobe |
| capture_en_i | input | 1 | Capture event strobe |
| transfer_en_i | input | 1 | Transfer (update to shift stage) strobe |
| update_en_i | input | 1 | Update (shift to update stage) strobe |
| apply_en_i | input | 1 | Drive stored value in the driving mode |
| scan_i | input | 1 | Serial data in |
| scan_o | output | 1 | Serial data out (shift stage MSB) |
| func_i | input | DW | Functional value from the terminal's source |
| func_o | output | DW | Value toward the terminal's destination |

## Verification
Several checks run on every clock cycle. The strobe arbiter never fires two events at once, and a shift always wins. A shift places the serial bit in bit 0, and a capture loads the functional word. The update stage moves only on an update event, which guards against ripple. In functional, safe and observing modes, `func_o` is held to its defined source. Other behaviour can only be shown by the bench's scenarios, because it needs a reference model over many cycles:

- what a value looks like after many shifts, captures and transfers, as seen at `scan_o`;
- what the driving mode applies;
- the difference between the variants with and without an update stage;
- the reset state.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

  typedef enum logic [1:0] {
    WBC_FUNC    = 2'b00,
    WBC_INWARD  = 2'b01,
    WBC_OUTWARD = 2'b10,
    WBC_SAFE    = 2'b11
  } wbc_mode_e;

  typedef struct packed {
    logic shift;
    logic capture;
    logic xfer;
    logic update;
  } wbc_fire_t;

endpackage

// File: rtl/wbc_rst_sync.sv
module wbc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/wbc_event_arb.sv
module wbc_event_arb
  import wbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shift_i,
  input  logic      capture_i,
  input  logic      xfer_i,
  input  logic      update_i,
  output wbc_fire_t fire_o
);
  always_comb begin
    fire_o = '0;
    if (shift_i)        fire_o.shift   = 1'b1;
    else if (capture_i) fire_o.capture = 1'b1;
    else if (xfer_i)    fire_o.xfer    = 1'b1;
    else if (update_i)  fire_o.update  = 1'b1;
  end

  // R7: at most one event acts per edge
  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_o));
  // R7: shift always wins
  assert_shift_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> fire_o.shift);
endmodule

// File: rtl/wbc_shift_stage.sv
module wbc_shift_stage #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_i,
  input  logic          capture_i,
  input  logic          xfer_i,
  input  logic          scan_i,
  input  logic [DW-1:0] func_i,
  input  logic [DW-1:0] xfer_src_i,
  output logic [DW-1:0] sreg_o
);
  logic [DW-1:0] sreg_q, sreg_d, shifted;
  logic          load;

  generate
    if (DW == 1) begin : g_one
      assign shifted = scan_i;
    end else begin : g_many
      assign shifted = {sreg_q[DW-2:0], scan_i};
    end
  endgenerate

  always_comb begin
    sreg_d = sreg_q;
    load   = 1'b0;
    if (shift_i) begin
      sreg_d = shifted;
      load   = 1'b1;
    end else if (capture_i) begin
      sreg_d = func_i;
      load   = 1'b1;
    end else if (xfer_i) begin
      sreg_d = xfer_src_i;
      load   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sreg_q <= '0;
    else if (load) sreg_q <= sreg_d;
  end

  assign sreg_o = sreg_q;

  // R3: serial bit lands in bit 0
  assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |=> sreg_q[0] == $past(scan_i));
  // R4: capture loads the functional word
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i && !shift_i |=> sreg_q == $past(func_i));
  // R7: no strobe, no change
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_i && !capture_i && !xfer_i |=> $stable(sreg_q));
endmodule

// File: rtl/wbc_update_stage.sv
module wbc_update_stage #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          update_i,
  input  logic [DW-1:0] sreg_i,
  output logic [DW-1:0] ureg_o
);
  logic [DW-1:0] ureg_q, ureg_d;

  always_comb begin
    ureg_d = update_i ? sreg_i : ureg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ureg_q <= '0;
    else if (update_i) ureg_q <= ureg_d;
  end

  assign ureg_o = ureg_q;

  // R5: update copies the shift stage
  assert_update_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    update_i |=> ureg_q == $past(sreg_i));
  // R10: no ripple while other events run
  assert_ripple_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !update_i |=> $stable(ureg_q));
endmodule

// File: rtl/wbc_out_mux.sv
module wbc_out_mux
  import wbc_pkg::*;
#(
  parameter int            DW         = 4,
  parameter logic [DW-1:0] SAFE_VALUE = '0,
  parameter wbc_mode_e     DRIVE_MODE = WBC_INWARD
) (
  input  wbc_mode_e     mode_i,
  input  logic          apply_i,
  input  logic [DW-1:0] func_i,
  input  logic [DW-1:0] stored_i,
  output logic [DW-1:0] func_o
);
  always_comb begin
    unique case (mode_i)
      WBC_FUNC: func_o = func_i;
      WBC_SAFE: func_o = SAFE_VALUE;
      default: begin
        if (mode_i == DRIVE_MODE && apply_i) func_o = stored_i;
        else                                 func_o = func_i;
      end
    endcase
  end
endmodule

// File: rtl/wbc_cell.sv
module wbc_cell
  import wbc_pkg::*;
#(
  parameter int            DW         = 4,
  parameter bit            HAS_UPDATE = 1'b1,
  parameter bit            CORE_INPUT = 1'b1,
  parameter logic [DW-1:0] SAFE_VALUE = '0
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic [1:0]    mode_i,
  input  logic          shift_en_i,
  input  logic          capture_en_i,
  input  logic          transfer_en_i,
  input  logic          update_en_i,
  input  logic          apply_en_i,
  input  logic          scan_i,
  output logic          scan_o,
  input  logic [DW-1:0] func_i,
  output logic [DW-1:0] func_o
);
  localparam wbc_mode_e DRIVE_MODE = CORE_INPUT ? WBC_INWARD : WBC_OUTWARD;
  localparam wbc_mode_e WATCH_MODE = CORE_INPUT ? WBC_OUTWARD : WBC_INWARD;

  logic          rst_n;
  wbc_fire_t     fire;
  wbc_mode_e     mode;
  logic [DW-1:0] sreg, stored;

  assign mode = wbc_mode_e'(mode_i);

  wbc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  wbc_event_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .shift_i(shift_en_i), .capture_i(capture_en_i),
    .xfer_i(transfer_en_i), .update_i(update_en_i),
    .fire_o(fire)
  );

  wbc_shift_stage #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_i(fire.shift), .capture_i(fire.capture), .xfer_i(fire.xfer),
    .scan_i(scan_i), .func_i(func_i), .xfer_src_i(stored),
    .sreg_o(sreg)
  );

  generate
    if (HAS_UPDATE) begin : g_upd
      wbc_update_stage #(.DW(DW)) u_update (
        .clk(clk), .rst_n(rst_n),
        .update_i(fire.update), .sreg_i(sreg), .ureg_o(stored)
      );
    end else begin : g_noupd
      assign stored = sreg;
    end
  endgenerate

  wbc_out_mux #(.DW(DW), .SAFE_VALUE(SAFE_VALUE), .DRIVE_MODE(DRIVE_MODE)) u_mux (
    .mode_i(mode), .apply_i(apply_en_i), .func_i(func_i),
    .stored_i(stored), .func_o(func_o)
  );

  assign scan_o = sreg[DW-1];

  // R1: functional mode is a straight path
  assert_func_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode == WBC_FUNC |-> func_o == func_i);
  // R2: safe mode forces the safe value
  assert_safe_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == WBC_SAFE |-> func_o == SAFE_VALUE);
  // R9: observing mode passes the functional value
  assert_observe_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode == WATCH_MODE |-> func_o == func_i);
  // R7: the four fire bits never overlap
  assert_fire_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({fire.shift, fire.capture, fire.xfer, fire.update}) <= 1);
endmodule

// File: tb/sim_wbc_cell.sv
`timescale 1ns/1ps
module sim_wbc_cell;
  logic       clk = 1'b0;
  logic       arst_n;
  logic [1:0] mode;
  logic       sh_en, ca_en, xf_en, up_en, ap_en, si;
  logic [3:0] fi;
  logic       so0, so1;
  logic [3:0] fo0, fo1;
  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // model state: u0 has update stage, drives inward; u1 no update, drives outward
  logic [3:0] m_sh0, m_up0, m_sh1;

  always #2 clk = ~clk;

  wbc_cell #(.DW(4), .HAS_UPDATE(1'b1), .CORE_INPUT(1'b1), .SAFE_VALUE(4'h5)) u0 (
    .clk(clk), .arst_n(arst_n), .mode_i(mode), .shift_en_i(sh_en),
    .capture_en_i(ca_en), .transfer_en_i(xf_en), .update_en_i(up_en),
    .apply_en_i(ap_en), .scan_i(si), .scan_o(so0), .func_i(fi), .func_o(fo0));

  wbc_cell #(.DW(4), .HAS_UPDATE(1'b0), .CORE_INPUT(1'b0), .SAFE_VALUE(4'hA)) u1 (
    .clk(clk), .arst_n(arst_n), .mode_i(mode), .shift_en_i(sh_en),
    .capture_en_i(ca_en), .transfer_en_i(xf_en), .update_en_i(up_en),
    .apply_en_i(ap_en), .scan_i(si), .scan_o(so1), .func_i(fi), .func_o(fo1));

  task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_out(input logic [1:0] m, input logic ap, input logic [3:0] f,
                                         input logic [3:0] st, input logic [1:0] drv, input logic [3:0] sv);
    if (m == 2'b00)             return f;
    if (m == 2'b11)             return sv;
    if (m == drv && ap)         return st;
    return f;
  endfunction

  function automatic string out_tag(input logic [1:0] m, input logic ap, input logic [1:0] drv);
    if (m == 2'b00)     return "R1";
    if (m == 2'b11)     return "R2";
    if (m == drv && ap) return "R8";
    if (m == drv)       return "R8";
    return "R9";
  endfunction

  function automatic string ev_tag(input logic s, c, x, u);
    int n = int'(s) + int'(c) + int'(x) + int'(u);
    if (n > 1) return "R7";
    if (s) return "R3";
    if (c) return "R4";
    if (x) return "R6";
    if (u) return "R5";
    return "R7";
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic step(input logic [1:0] m, input logic ap, input logic s, c, x, u,
                      input logic sin, input logic [3:0] f, input string tag0);
    string t0;
    @(negedge clk);
    mode = m; ap_en = ap; sh_en = s; ca_en = c; xf_en = x; up_en = u; si = sin; fi = f;
    #0.5;
    t0 = (tag0 != "") ? tag0 : out_tag(m, ap, 2'b01);
    chk(t0, "u0 func_o", fo0, exp_out(m, ap, f, m_up0, 2'b01, 4'h5));
    chk(out_tag(m, ap, 2'b10), "u1 func_o", fo1, exp_out(m, ap, f, m_sh1, 2'b10, 4'hA));
    @(posedge clk);
    if (s) begin
      m_sh0 = {m_sh0[2:0], sin};
      m_sh1 = {m_sh1[2:0], sin};
    end else if (c) begin
      m_sh0 = f;
      m_sh1 = f;
    end else if (x) begin
      m_sh0 = m_up0;
    end else if (u) begin
      m_up0 = m_sh0;
    end
    #0.5;
    chk(ev_tag(s, c, x, u), "u0 scan_o", {3'b0, so0}, {3'b0, m_sh0[3]});
    chk(ev_tag(s, c, x, u), "u1 scan_o", {3'b0, so1}, {3'b0, m_sh1[3]});
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; mode = 2'b00; sh_en = 0; ca_en = 0; xf_en = 0; up_en = 0;
    ap_en = 0; si = 0; fi = 4'h0;
    m_sh0 = '0; m_up0 = '0; m_sh1 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); arst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11: reset state visible through scan_o and applied output
    @(negedge clk); mode = 2'b01; ap_en = 1; fi = 4'hF; #0.5;
    chk("R11", "u0 applied after reset", fo0, 4'h0);
    chk("R11", "u0 scan_o after reset", {3'b0, so0}, 4'h0);
    @(negedge clk); mode = 2'b10; #0.5;
    chk("R11", "u1 applied after reset", fo1, 4'h0);
    chk("R11", "u1 scan_o after reset", {3'b0, so1}, 4'h0);

    // R10: load 4'b1011 into u0 update stage, then shift with output applied
    step(2'b01, 0, 1, 0, 0, 0, 1, 4'h0, "");
    step(2'b01, 0, 1, 0, 0, 0, 0, 4'h0, "");
    step(2'b01, 0, 1, 0, 0, 0, 1, 4'h0, "");
    step(2'b01, 0, 1, 0, 0, 0, 1, 4'h0, "");
    step(2'b01, 0, 0, 0, 0, 1, 0, 4'h0, "R5");
    for (int k = 0; k < 8; k++) begin
      step(2'b01, 1, 1, 0, 0, 0, k[0], 4'h3, "R10");
      chk("R10", "u0 applied holds", fo0, 4'hB);
    end
    // R6: transfer back and shift out
    step(2'b01, 1, 0, 0, 1, 0, 0, 4'h0, "R6");
    for (int k = 0; k < 4; k++) step(2'b00, 0, 1, 0, 0, 0, 0, 4'h6, "");

    // sweep all modes x apply x strobe combinations with varied data
    for (int rep = 0; rep < 6; rep++) begin
      for (int combo = 0; combo < 128; combo++) begin
        logic [6:0] cb = combo[6:0];
        lfsr = lfsr_next(lfsr);
        step(cb[6:5], cb[4], cb[3], cb[2], cb[1], cb[0], lfsr[0], lfsr[7:4], "");
      end
    end

    // R11: asynchronous reset mid-run clears both stages
    @(negedge clk); arst_n = 1'b0; sh_en = 0; ca_en = 0; xf_en = 0; up_en = 0; #0.5;
    m_sh0 = '0; m_up0 = '0; m_sh1 = '0;
    mode = 2'b01; ap_en = 1; fi = 4'h9; #0.5;
    chk("R11", "u0 applied in reset", fo0, 4'h0);
    chk("R11", "u1 scan_o in reset", {3'b0, so1}, 4'h0);
    @(negedge clk); arst_n = 1'b1;
    repeat (3) @(posedge clk);
    step(2'b10, 1, 0, 1, 0, 0, 0, 4'hC, "");
    step(2'b10, 1, 0, 0, 0, 0, 0, 4'h1, "");

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule